// File: doc/BRIEF.md
# MSI Line Coherence and Latency Accounting Unit

This unit follows a single memory line that four processors share over one snooping bus. It keeps the line's coherence state in each of the four private caches under an MSI protocol. Each cycle it accepts at most one reference: a read, a write or an eviction, together with the index of the processor that issues it. When a reference is accepted, the unit does five things. It moves every cache to its next state. It reports the bus transaction that the reference causes. It reports where the data comes from. It classifies the reference by latency. It adds that latency to a cycle total that saturates.

Each cache is a small state machine with three states: Invalid (`ST_INV`), Shared (`ST_SHR`) and Modified (`ST_MOD`).

The requester takes these transitions:
- `ST_INV` on read goes to `ST_SHR`.
- `ST_INV` on write goes to `ST_MOD`.
- `ST_SHR` on write goes to `ST_MOD`.
- `ST_SHR` on evict goes to `ST_INV`.
- `ST_MOD` on evict goes to `ST_INV`.
- Every other requester case keeps its state.

The other caches see one of three snoop events:
- `SN_SHARE` moves `ST_MOD` to `ST_SHR`.
- `SN_KILL` moves any state to `ST_INV`.
- `SN_NONE` changes nothing.

A central controller classifies each reference into one of six kinds: `K_NOP`, `K_HIT`, `K_UPG`, `K_MISS_MEM`, `K_MISS_PEER` and `K_WB`. A cost stage turns the kind into a cycle charge and adds it to the total.

All outputs are registered. They show the result of a reference on the clock edge at which that reference is sampled.

Top module: `coh_cost_tracker`

## Requirements
- R1: After reset every cache reads Invalid. The bus code, data source, last cost and total are all zero.
  - Encodings: op 0 is read, 1 is write, 2 is evict and 3 is reserved.
  - State codes: 0 is Invalid, 1 is Shared and 2 is Modified. Cache i occupies bits [2i+1:2i] of `cache_state`.
  - Bus codes: 0 none, 1 read, 2 read-exclusive, 3 upgrade, 4 write-back.
  - Source codes: 0 none, 1 memory, 2 peer cache.
- R2: A read by a cache in Shared or Modified issues no bus transaction. Its source is none, it costs 1 cycle, and no state changes.
- R3: A read by a cache in Invalid while no other cache is Modified issues a bus read. Data comes from memory at a cost of 80. The requester becomes Shared and the other caches keep their state.
- R4: A read by a cache in Invalid while another cache is Modified issues a bus read. The owner supplies the data, so the source is peer, the cost is 50, and the owner drops to Shared. The requester becomes Shared.
- R5: A write by a cache in Shared issues an upgrade. The source is none and the cost is 10. The requester becomes Modified and every other cache becomes Invalid.
- R6: A write by a cache in Invalid issues a read-exclusive. Data comes from a peer (cost 50) if another cache is Modified, otherwise from memory (cost 80). The requester becomes Modified and all others become Invalid.
- R7: A write by a cache in Modified issues no bus transaction. Its source is none and it costs 1 cycle.
- R8: Eviction leaves the requester Invalid. The effect depends on the requester's state:
  - From Modified, it issues a write-back and costs 1.
  - From Shared, it issues nothing and costs 1.
  - From Invalid, it issues nothing, costs 0 and changes nothing.
- R9: The total grows by exactly the cost of each accepted reference. It holds at all ones instead of wrapping.
- R10: A cycle with `ref_valid` low, or one carrying the reserved op 3, changes no state and no output.
- R11: At most one cache is Modified. When one is, every other cache is Invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ref_valid | input | 1 | A reference is presented this cycle |
| ref_op | input | 2 | Reference kind (0 read, 1 write, 2 evict, 3 reserved) |
| ref_cpu | input | CPU_W (2) | Issuing processor index |
| cache_state | output | 2*NCPU (8) | Packed per-cache line states |
| bus_code | output | 3 | Bus transaction of the last reference |
| data_src | output | 2 | Data source of the last reference |
| ref_cost | output | COST_W (8) | Cycle cost of the last reference |
| cost_total | output | TOTAL_W (32) | Saturating running cycle total |

## Verification
Two functions share a single cycle: the requester's own transition and the snoop transition that the same reference forces on another cache. This happens on a read miss or a write miss while a peer holds Modified. The bench provokes it by having one processor write and then having a different processor read or write. It judges the result by comparing the whole packed state word in one sample: the owner must show Shared (read) or Invalid (write) in the same cycle that the requester shows its new state, with the peer source and a cost of 50. A second coincidence is the saturating add landing on the same edge as a miss charge. The bench drives enough consecutive misses to cross the limit and compares the total with a clamped model after every reference.

// File: rtl/coh_pkg.sv
`timescale 1ns/1ps
package coh_pkg;

    typedef enum logic [1:0] {
        ST_INV = 2'd0,
        ST_SHR = 2'd1,
        ST_MOD = 2'd2
    } line_st_e;

    typedef enum logic [1:0] {
        OP_RD  = 2'd0,
        OP_WR  = 2'd1,
        OP_EV  = 2'd2,
        OP_RSV = 2'd3
    } ref_op_e;

    typedef enum logic [2:0] {
        BUS_NONE = 3'd0,
        BUS_RD   = 3'd1,
        BUS_RDX  = 3'd2,
        BUS_UPGR = 3'd3,
        BUS_WB   = 3'd4
    } bus_e;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_MEM  = 2'd1,
        SRC_PEER = 2'd2
    } src_e;

    typedef enum logic [2:0] {
        K_NOP       = 3'd0,
        K_HIT       = 3'd1,
        K_UPG       = 3'd2,
        K_MISS_MEM  = 3'd3,
        K_MISS_PEER = 3'd4,
        K_WB        = 3'd5
    } kind_e;

    typedef enum logic [1:0] {
        SN_NONE  = 2'd0,
        SN_SHARE = 2'd1,
        SN_KILL  = 2'd2
    } snoop_e;

endpackage

// File: rtl/coh_line_fsm.sv
`timescale 1ns/1ps
module coh_line_fsm
    import coh_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     req_en,
    input  ref_op_e  req_op,
    input  snoop_e   snoop,
    output line_st_e state_q
);

    line_st_e state_d;

    // Next-state logic: requester transitions or snoop reactions
    always_comb begin
        state_d = state_q;
        if (req_en) begin
            unique case (state_q)
                ST_INV: begin
                    if (req_op == OP_RD)      state_d = ST_SHR;
                    else if (req_op == OP_WR) state_d = ST_MOD;
                end
                ST_SHR: begin
                    if (req_op == OP_WR)      state_d = ST_MOD;
                    else if (req_op == OP_EV) state_d = ST_INV;
                end
                ST_MOD: begin
                    if (req_op == OP_EV)      state_d = ST_INV;
                end
                default: state_d = ST_INV;
            endcase
        end else begin
            unique case (snoop)
                SN_SHARE: if (state_q == ST_MOD) state_d = ST_SHR;
                SN_KILL:  state_d = ST_INV;
                default:  state_d = state_q;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_INV;
        else        state_q <= state_d;
    end

    AST_EVICT_LEAVES_INV: assert property (@(posedge clk) disable iff (!rst_n)
        (req_en && req_op == OP_EV) |=> (state_q == ST_INV)); // R8

    AST_KILL_INVALIDATES: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_en && snoop == SN_KILL) |=> (state_q == ST_INV)); // R6

    AST_SHARE_NO_MOD: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_en && snoop == SN_SHARE) |=> (state_q != ST_MOD)); // R4

endmodule

// File: rtl/coh_ref_ctrl.sv
`timescale 1ns/1ps
module coh_ref_ctrl
    import coh_pkg::*;
#(
    parameter int NCPU  = 4,
    parameter int CPU_W = $clog2(NCPU)
) (
    input  logic             ref_valid,
    input  logic [1:0]       ref_op,
    input  logic [CPU_W-1:0] ref_cpu,
    input  line_st_e         st_i [NCPU],
    output logic             live,
    output logic [NCPU-1:0]  req_en,
    output ref_op_e          req_op,
    output snoop_e           snoop,
    output bus_e             bus_d,
    output kind_e            kind_d
);

    line_st_e own_st;
    logic     peer_mod;

    always_comb begin
        req_op   = ref_op_e'(ref_op);
        live     = ref_valid && (req_op != OP_RSV);
        own_st   = st_i[ref_cpu];
        peer_mod = 1'b0;
        for (int i = 0; i < NCPU; i++) begin
            if ((i != int'(ref_cpu)) && (st_i[i] == ST_MOD)) peer_mod = 1'b1;
        end
        req_en = '0;
        if (live) req_en[ref_cpu] = 1'b1;
    end

    // Reference classification: bus action, snoop broadcast, latency kind
    always_comb begin
        bus_d  = BUS_NONE;
        snoop  = SN_NONE;
        kind_d = K_NOP;
        if (live) begin
            unique case (req_op)
                OP_RD: begin
                    if (own_st == ST_INV) begin
                        bus_d  = BUS_RD;
                        snoop  = SN_SHARE;
                        kind_d = peer_mod ? K_MISS_PEER : K_MISS_MEM;
                    end else begin
                        kind_d = K_HIT;
                    end
                end
                OP_WR: begin
                    unique case (own_st)
                        ST_INV: begin
                            bus_d  = BUS_RDX;
                            snoop  = SN_KILL;
                            kind_d = peer_mod ? K_MISS_PEER : K_MISS_MEM;
                        end
                        ST_SHR: begin
                            bus_d  = BUS_UPGR;
                            snoop  = SN_KILL;
                            kind_d = K_UPG;
                        end
                        default: kind_d = K_HIT;
                    endcase
                end
                OP_EV: begin
                    unique case (own_st)
                        ST_MOD: begin
                            bus_d  = BUS_WB;
                            kind_d = K_WB;
                        end
                        ST_SHR:  kind_d = K_HIT;
                        default: kind_d = K_NOP;
                    endcase
                end
                default: kind_d = K_NOP;
            endcase
        end
    end

endmodule

// File: rtl/coh_cost_accum.sv
`timescale 1ns/1ps
module coh_cost_accum
    import coh_pkg::*;
#(
    parameter int COST_W    = 8,
    parameter int TOTAL_W   = 32,
    parameter int COST_HIT  = 1,
    parameter int COST_UPG  = 10,
    parameter int COST_PEER = 50,
    parameter int COST_MEM  = 80
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               live,
    input  kind_e              kind_d,
    output src_e               src_q,
    output logic [COST_W-1:0]  cost_q,
    output logic [TOTAL_W-1:0] total_q
);

    localparam logic [TOTAL_W-1:0] TOTAL_MAX = '1;

    logic [COST_W-1:0]  cost_d;
    src_e               src_d;
    logic [TOTAL_W:0]   sum_w;

    always_comb begin
        unique case (kind_d)
            K_HIT, K_WB: begin cost_d = COST_W'(COST_HIT);  src_d = SRC_NONE; end
            K_UPG:       begin cost_d = COST_W'(COST_UPG);  src_d = SRC_NONE; end
            K_MISS_PEER: begin cost_d = COST_W'(COST_PEER); src_d = SRC_PEER; end
            K_MISS_MEM:  begin cost_d = COST_W'(COST_MEM);  src_d = SRC_MEM;  end
            default:     begin cost_d = '0;                 src_d = SRC_NONE; end
        endcase
        sum_w = {1'b0, total_q} + (TOTAL_W+1)'(cost_d);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q   <= SRC_NONE;
            cost_q  <= '0;
            total_q <= '0;
        end else if (live) begin
            src_q   <= src_d;
            cost_q  <= cost_d;
            total_q <= sum_w[TOTAL_W] ? TOTAL_MAX : sum_w[TOTAL_W-1:0];
        end
    end

    AST_TOTAL_NEVER_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        total_q >= $past(total_q)); // R9

    AST_TOTAL_HOLDS_AT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        (total_q == TOTAL_MAX) |=> (total_q == TOTAL_MAX)); // R9

endmodule

// File: rtl/coh_cost_tracker.sv
`timescale 1ns/1ps
module coh_cost_tracker
    import coh_pkg::*;
#(
    parameter int NCPU      = 4,
    parameter int CPU_W     = $clog2(NCPU),
    parameter int COST_W    = 8,
    parameter int TOTAL_W   = 32,
    parameter int COST_HIT  = 1,
    parameter int COST_UPG  = 10,
    parameter int COST_PEER = 50,
    parameter int COST_MEM  = 80
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ref_valid,
    input  logic [1:0]          ref_op,
    input  logic [CPU_W-1:0]    ref_cpu,
    output logic [2*NCPU-1:0]   cache_state,
    output logic [2:0]          bus_code,
    output logic [1:0]          data_src,
    output logic [COST_W-1:0]   ref_cost,
    output logic [TOTAL_W-1:0]  cost_total
);

    line_st_e        st [NCPU];
    logic            live;
    logic [NCPU-1:0] req_en;
    ref_op_e         req_op;
    snoop_e          snoop;
    bus_e            bus_d;
    bus_e            bus_q;
    kind_e           kind_d;
    src_e            src_q;
    logic [NCPU-1:0] is_mod;
    logic [NCPU-1:0] is_val;

    coh_ref_ctrl #(.NCPU(NCPU), .CPU_W(CPU_W)) ctrl_i (
        .ref_valid (ref_valid),
        .ref_op    (ref_op),
        .ref_cpu   (ref_cpu),
        .st_i      (st),
        .live      (live),
        .req_en    (req_en),
        .req_op    (req_op),
        .snoop     (snoop),
        .bus_d     (bus_d),
        .kind_d    (kind_d)
    );

    for (genvar g = 0; g < NCPU; g++) begin : g_line
        coh_line_fsm line_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .req_en  (req_en[g]),
            .req_op  (req_op),
            .snoop   (snoop),
            .state_q (st[g])
        );
        assign cache_state[2*g +: 2] = st[g];
        assign is_mod[g] = (st[g] == ST_MOD);
        assign is_val[g] = (st[g] != ST_INV);
    end

    coh_cost_accum #(
        .COST_W(COST_W), .TOTAL_W(TOTAL_W), .COST_HIT(COST_HIT),
        .COST_UPG(COST_UPG), .COST_PEER(COST_PEER), .COST_MEM(COST_MEM)
    ) accum_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .live    (live),
        .kind_d  (kind_d),
        .src_q   (src_q),
        .cost_q  (ref_cost),
        .total_q (cost_total)
    );

    // Bus transaction register
    always_ff @(posedge clk) begin
        if (!rst_n)    bus_q <= BUS_NONE;
        else if (live) bus_q <= bus_d;
    end

    assign bus_code = bus_q;
    assign data_src = src_q;

    AST_SINGLE_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
        (|is_mod) |-> ($countones(is_val) == 1)); // R11

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!ref_valid || ref_op == 2'd3) |=> ($stable(cache_state) && $stable(cost_total) && $stable(bus_code))); // R10

    AST_READ_HIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_valid && ref_op == 2'd0 && st[ref_cpu] != ST_INV)
        |=> (bus_code == 3'd0 && ref_cost == COST_W'(COST_HIT))); // R2

endmodule

// File: tb/coh_cost_tracker_tb.sv
`timescale 1ns/1ps
module coh_cost_tracker_tb_top;

    localparam int TW  = 12;
    localparam int NV  = 19;
    localparam int VW  = 26;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ref_valid = 1'b0;
    logic [1:0]    ref_op = 2'd0;
    logic [1:0]    ref_cpu = 2'd0;
    logic [7:0]    cache_state;
    logic [2:0]    bus_code;
    logic [1:0]    data_src;
    logic [7:0]    ref_cost;
    logic [TW-1:0] cost_total;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    coh_cost_tracker #(.TOTAL_W(TW)) dut_i (
        .clk(clk), .rst_n(rst_n), .ref_valid(ref_valid), .ref_op(ref_op),
        .ref_cpu(ref_cpu), .cache_state(cache_state), .bus_code(bus_code),
        .data_src(data_src), .ref_cost(ref_cost), .cost_total(cost_total)
    );

    // {valid, op, cpu, states(c3..c0), bus, src, cost}
    localparam logic [VW-1:0] VEC [NV] = '{
        {1'b1, 2'd0, 2'd0, 8'h01, 3'd1, 2'd1, 8'd80},
        {1'b1, 2'd0, 2'd1, 8'h05, 3'd1, 2'd1, 8'd80},
        {1'b1, 2'd0, 2'd2, 8'h15, 3'd1, 2'd1, 8'd80},
        {1'b1, 2'd0, 2'd1, 8'h15, 3'd0, 2'd0, 8'd1},
        {1'b1, 2'd1, 2'd2, 8'h20, 3'd3, 2'd0, 8'd10},
        {1'b1, 2'd2, 2'd2, 8'h00, 3'd4, 2'd0, 8'd1},
        {1'b1, 2'd1, 2'd3, 8'h80, 3'd2, 2'd1, 8'd80},
        {1'b1, 2'd0, 2'd1, 8'h44, 3'd1, 2'd2, 8'd50},
        {1'b1, 2'd0, 2'd2, 8'h54, 3'd1, 2'd1, 8'd80},
        {1'b1, 2'd1, 2'd0, 8'h02, 3'd2, 2'd1, 8'd80},
        {1'b1, 2'd1, 2'd0, 8'h02, 3'd0, 2'd0, 8'd1},
        {1'b1, 2'd0, 2'd0, 8'h02, 3'd0, 2'd0, 8'd1},
        {1'b1, 2'd1, 2'd1, 8'h08, 3'd2, 2'd2, 8'd50},
        {1'b0, 2'd0, 2'd0, 8'h08, 3'd2, 2'd2, 8'd50},
        {1'b1, 2'd3, 2'd2, 8'h08, 3'd2, 2'd2, 8'd50},
        {1'b1, 2'd2, 2'd3, 8'h08, 3'd0, 2'd0, 8'd0},
        {1'b1, 2'd0, 2'd3, 8'h44, 3'd1, 2'd2, 8'd50},
        {1'b1, 2'd2, 2'd3, 8'h04, 3'd0, 2'd0, 8'd1},
        {1'b1, 2'd1, 2'd1, 8'h08, 3'd3, 2'd0, 8'd10}
    };

    localparam string TAG [NV] = '{
        "R3", "R3", "R3", "R2", "R5", "R8", "R6", "R4", "R3", "R6",
        "R7", "R2", "R6", "R10", "R10", "R8", "R4", "R8", "R5"
    };

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        ref_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(200000 * 4);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] model;
        do_reset();
        // R1 reset state
        check("R1", "states", cache_state, 8'h00);
        check("R1", "bus", bus_code, 3'd0);
        check("R1", "src", data_src, 2'd0);
        check("R1", "cost", ref_cost, 8'd0);
        check("R1", "total", cost_total, 0);

        model = 0;
        for (int i = 0; i < NV; i++) begin
            logic [VW-1:0] v;
            v = VEC[i];
            ref_valid = v[25];
            ref_op    = v[24:23];
            ref_cpu   = v[22:21];
            if (v[25] && v[24:23] != 2'd3) model = model + v[7:0];
            @(negedge clk);
            check(TAG[i], "states", cache_state, v[20:13]);
            check(TAG[i], "bus", bus_code, v[12:10]);
            check(TAG[i], "src", data_src, v[9:8]);
            check(TAG[i], "cost", ref_cost, v[7:0]);
            check("R9", "total", cost_total, model);
        end
        ref_valid = 1'b0;

        // R1 mid-run reset clears everything
        do_reset();
        check("R1", "states after reset", cache_state, 8'h00);
        check("R1", "total after reset", cost_total, 0);

        // R9 saturation through alternating write misses (R6 ping-pong)
        model = 0;
        for (int k = 0; k < 90; k++) begin
            ref_valid = 1'b1;
            ref_op    = 2'd1;
            ref_cpu   = 2'(k % 2);
            model = model + ((k == 0) ? 80 : 50);
            if (model > 4095) model = 4095;
            @(negedge clk);
            check("R9", "saturating total", cost_total, model);
        end
        check("R6", "final ping-pong states", cache_state, 8'h08);
        check("R9", "clamped total", cost_total, 4095);
        ref_valid = 1'b0;
        @(negedge clk);
        check("R10", "idle after saturation", cost_total, 4095);

        finish_run();
    end

endmodule